// File: doc/BRIEF.md
# Boot ROM Image Bank Selector

This block drives the two most significant address lines of a 1 MB boot flash that permanently holds three boot images: one of 512 kB and two of 256 kB. Exactly one image is visible to the CPU at any time. Choosing a different image changes only a configuration value and never rewrites the flash.

The two bank lines form their own small bus and are never shared with, or multiplexed onto, RAM addressing.

- With a 256 kB image selected, both bank lines are constant.
- With the 512 kB image selected, the upper bank line is held at 0 and the lower one follows CPU address line A18. Passing that line through adds logic delay in the address path, so during every ROM-select cycle the block asks the wait-state generator for one extra ROM wait state.

The image select input is quasi-static. It is captured once, on the first clock edge after reset is released, so the bank cannot change in the middle of an access.

Top module: `rom_bank_sel`

## Requirements
- R1: While rst_ni is low, bank_o is 2'b11 (the default high-density-floppy 256 kB image) and rom_wait_o is 0.
- R2: img_sel_i is captured on the first rising clock edge after rst_ni goes high. Later changes of img_sel_i have no effect on bank_o or rom_wait_o until the next reset.
- R3: Select code 2'b11 (high-density-floppy 256 kB image) gives bank_o = 2'b11 whatever the value of cpu_a18_i.
- R4: Select code 2'b10 (original 256 kB image) gives bank_o = 2'b10 whatever the value of cpu_a18_i.
- R5: Select code 2'b00 (512 kB image) gives bank_o[1] = 0, and bank_o[0] equal to cpu_a18_i in the same cycle, with no register in between.
- R6: The reserved select code 2'b01 behaves exactly like the default code 2'b11.
- R7: rom_wait_o is 1 exactly when rom_sel_i is 1 and the 512 kB image is selected. It follows rom_sel_i combinationally.
- R8: With either 256 kB image selected, rom_wait_o stays 0 even while rom_sel_i is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| img_sel_i | input | 2 | Boot image select code, captured after reset |
| rom_sel_i | input | 1 | CPU ROM-select strobe for the current cycle |
| cpu_a18_i | input | 1 | CPU address line A18 |
| bank_o | output | 2 | Flash address bits 19:18 |
| rom_wait_o | output | 1 | Request for one extra ROM wait state |

## Verification
In 512 kB mode, the A18 pass-through and the wait request can act in the same ROM-select cycle. The bench toggles cpu_a18_i and rom_sel_i together across every combination of levels. After each change it checks that both outputs reflect the new inputs within that cycle. It also changes img_sel_i during ROM accesses after the capture edge and confirms that neither output moves.

// File: rtl/rom_bank_pkg.sv
package rom_bank_pkg;
  localparam int BANK_W = 2;

  typedef enum logic [BANK_W-1:0] {
    MODE_PASS = 2'b00,
    MODE_LOW  = 2'b10,
    MODE_HIGH = 2'b11
  } img_mode_t;

  localparam img_mode_t MODE_DEFAULT = MODE_HIGH;

  function automatic img_mode_t decode_sel(input logic [BANK_W-1:0] sel);
    case (sel)
      2'b00:   return MODE_PASS;
      2'b10:   return MODE_LOW;
      2'b11:   return MODE_HIGH;
      default: return MODE_DEFAULT; // reserved code
    endcase
  endfunction
endpackage

// File: rtl/rom_bank_cfg.sv
module rom_bank_cfg
  import rom_bank_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BANK_W-1:0] img_sel_i,
  output img_mode_t         mode_o,
  output logic              loaded_o
);
  img_mode_t mode_q;
  logic      loaded_q;

  // one-shot capture after reset release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= MODE_DEFAULT;
      loaded_q <= 1'b0;
    end else if (!loaded_q) begin
      mode_q   <= decode_sel(img_sel_i);
      loaded_q <= 1'b1;
    end
  end

  assign mode_o   = mode_q;
  assign loaded_o = loaded_q;

  AST_CFG_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loaded_q |=> $stable(mode_q)); // R2
endmodule

// File: rtl/rom_bank_mux.sv
module rom_bank_mux
  import rom_bank_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  img_mode_t         mode_i,
  input  logic              loaded_i,
  input  logic              a18_i,
  output logic [BANK_W-1:0] bank_o
);
  always_comb begin
    case (mode_i)
      MODE_PASS: bank_o = {1'b0, a18_i};
      MODE_LOW:  bank_o = 2'b10;
      default:   bank_o = 2'b11;
    endcase
  end

  AST_UPPER_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loaded_i |=> $stable(bank_o[1])); // R5
  AST_STATIC_BANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loaded_i && mode_i != MODE_PASS) |=> $stable(bank_o)); // R3
endmodule

// File: rtl/rom_bank_wait.sv
module rom_bank_wait
  import rom_bank_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  img_mode_t mode_i,
  input  logic      rom_sel_i,
  output logic      wait_o
);
  assign wait_o = rom_sel_i && (mode_i == MODE_PASS);

  AST_WAIT_ON_ROM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_o |-> rom_sel_i); // R7
endmodule

// File: rtl/rom_bank_sel.sv
module rom_bank_sel
  import rom_bank_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BANK_W-1:0] img_sel_i,
  input  logic              rom_sel_i,
  input  logic              cpu_a18_i,
  output logic [BANK_W-1:0] bank_o,
  output logic              rom_wait_o
);
  img_mode_t mode;
  logic      loaded;

  rom_bank_cfg u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .img_sel_i(img_sel_i),
    .mode_o   (mode),
    .loaded_o (loaded)
  );

  rom_bank_mux u_mux (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mode_i  (mode),
    .loaded_i(loaded),
    .a18_i   (cpu_a18_i),
    .bank_o  (bank_o)
  );

  rom_bank_wait u_wait (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mode_i   (mode),
    .rom_sel_i(rom_sel_i),
    .wait_o   (rom_wait_o)
  );

  AST_WAIT_LOW_BANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_wait_o |-> (bank_o[1] == 1'b0)); // R8
  AST_BANK_KNOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$isunknown({bank_o, rom_wait_o})); // R3
endmodule

// File: tb/rom_bank_sel_bench.sv
module rom_bank_sel_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] img_sel_i = 2'b00;
  logic       rom_sel_i = 1'b0;
  logic       cpu_a18_i = 1'b0;
  logic [1:0] bank_o;
  logic       rom_wait_o;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  rom_bank_sel u_rom_bank_sel (
    .clk_i(clk_i), .rst_ni(rst_ni), .img_sel_i(img_sel_i),
    .rom_sel_i(rom_sel_i), .cpu_a18_i(cpu_a18_i),
    .bank_o(bank_o), .rom_wait_o(rom_wait_o)
  );

  task automatic check(input string req, input logic [1:0] exp_bank, input logic exp_wait);
    n_chk++;
    if (bank_o !== exp_bank || rom_wait_o !== exp_wait) begin
      n_bad++;
      $display("FAIL %s: bank=%b wait=%b expected bank=%b wait=%b",
               req, bank_o, rom_wait_o, exp_bank, exp_wait);
    end
  endtask

  // reset, then release and pass the capture edge with sel applied
  task automatic boot(input logic [1:0] sel);
    @(negedge clk_i);
    rst_ni = 1'b0; rom_sel_i = 1'b0; cpu_a18_i = 1'b0;
    img_sel_i = sel;
    @(negedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic t_reset_state();
    @(negedge clk_i);
    rst_ni = 1'b0; img_sel_i = 2'b00; rom_sel_i = 1'b1; cpu_a18_i = 1'b1;
    #1 check("R1 reset default", 2'b11, 1'b0);
    @(negedge clk_i);
    check("R1 reset held", 2'b11, 1'b0);
  endtask

  task automatic t_static(input logic [1:0] sel, input logic [1:0] exp, input string req);
    boot(sel);
    for (int i = 0; i < 4; i++) begin
      cpu_a18_i = i[0]; rom_sel_i = i[1];
      #1 check(req, exp, 1'b0);
      @(negedge clk_i);
    end
  endtask

  task automatic t_pass_and_wait();
    boot(2'b00);
    for (int i = 0; i < 4; i++) begin
      cpu_a18_i = i[0]; rom_sel_i = i[1];
      #1 check("R5 pass-through", {1'b0, i[0]}, i[1]);
      check("R7 wait with rom select", {1'b0, i[0]}, i[1]);
      @(negedge clk_i);
    end
  endtask

  task automatic t_frozen();
    boot(2'b00);
    img_sel_i = 2'b11; rom_sel_i = 1'b1; cpu_a18_i = 1'b1;
    repeat (3) @(negedge clk_i);
    check("R2 select frozen (pass stays)", 2'b01, 1'b1);
    boot(2'b10);
    img_sel_i = 2'b00; rom_sel_i = 1'b1; cpu_a18_i = 1'b1;
    repeat (3) @(negedge clk_i);
    check("R2 select frozen (low stays)", 2'b10, 1'b0);
  endtask

  initial begin
    fork
      begin
        t_reset_state();
        t_static(2'b11, 2'b11, "R3 high image static");
        t_static(2'b10, 2'b10, "R4 low image static");
        t_static(2'b01, 2'b11, "R6 reserved code");
        t_static(2'b11, 2'b11, "R8 no wait in static mode");
        t_pass_and_wait();
        t_frozen();
      end
      begin
        repeat (5000) @(posedge clk_i);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run hung, expected completion");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule